// File: doc/BRIEF.md
# I/O Translation Unit Memory-Mapped Control Register File

This block is the software-visible register bank of an I/O address translation unit. A host issues single 32-bit or 64-bit reads and writes over a request/response bus made of a byte offset, a size code and a full 64-bit data word. The block answers every request one cycle later with read data and a status code.

It stores three 64-bit base registers: one for the device table, one for the command ring and one for the event ring. It also stores a pair of 32-bit registers that share a single 8-byte slot. Each base register keeps only its writable bits. The command and event base registers each carry a 4-bit ring-length code. The block decodes that code continuously into an entry count, a byte size and an invalid-length flag, and the ring-processing logic next to it reads those three results. Offsets inside the two decoded windows that have no storage read as zero. Offsets outside the windows read as zero and return an unmapped status.

Top module: `iommu_regfile`

## Requirements
- R1: After reset every stored register reads zero, `rsp_valid_o` is low, both rings report zero entries and zero bytes, and both length-invalid flags are high.
- R2: A request seen at a rising clock edge produces exactly one `rsp_valid_o` pulse in the following cycle, and `rsp_valid_o` is low in any cycle that follows a cycle with no request.
- R3: Size code 2 means a 4-byte access and size code 3 means an 8-byte access. An access with size code 0 or 1, or with an offset not aligned to its size, returns status 2 (error) with zero data and changes no register.
- R4: The device-table base register at offset 0x000 keeps only the bits in 0x000F_FFFF_FFFF_F3FF. All other bits read back as zero.
- R5: The command base register at 0x008 and the event base register at 0x010 keep only the bits in 0x0F0F_FFFF_FFFF_F000.
- R6: A 4-byte access at an offset of 4 mod 8 addresses bits 63:32 of the 64-bit slot. A 4-byte read returns the addressed half in data bits 31:0 and zeros in bits 63:32. A 4-byte write changes only the addressed half, and the register's mask still applies.
- R7: The ring-length code sits in bits 59:56 of the command and event base registers. A code of 8 or more gives 2^code entries and 16*2^code bytes with the invalid flag low. A code of 7 or less gives zero entries, zero bytes and the invalid flag high.
- R8: Offsets 0x000 to 0x258 and 0x1FF8 to 0x2090, both ends included, are known. A read of a known offset with no storage returns zero with status 0 (ok). A read of any other offset returns zero with status 1 (unmapped).
- R9: A legal write to an unknown offset, or to a known offset with no storage, returns status 0 and changes no register.
- R10: Two 32-bit registers sit at 0x158 and 0x15C, and all 32 bits of each are writable. An 8-byte read at 0x158 returns the 0x158 register in bits 31:0 and the 0x15C register in bits 63:32. An 8-byte write there updates both registers the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 14 | Byte offset into the register space |
| req_size_i | input | 2 | Size code: 2 = 4 bytes, 3 = 8 bytes, other codes are illegal |
| req_wdata_i | input | 64 | Write data; a 4-byte write uses bits 31:0 |
| rsp_valid_o | output | 1 | Response present |
| rsp_rdata_o | output | 64 | Read data (zero for writes, errors and unmapped reads) |
| rsp_status_o | output | 2 | 0 = ok, 1 = unmapped, 2 = error |
| cmd_entries_o | output | 16 | Decoded command-ring entry count |
| cmd_bytes_o | output | 20 | Decoded command-ring byte size |
| cmd_len_bad_o | output | 1 | Command-ring length code is invalid |
| evt_entries_o | output | 16 | Decoded event-ring entry count |
| evt_bytes_o | output | 20 | Decoded event-ring byte size |
| evt_len_bad_o | output | 1 | Event-ring length code is invalid |

## Verification
A request is captured at one rising edge. Its response and any register update both become visible after that same edge, so the response is due one cycle later and the ring-decode outputs follow with no further delay. The bench drives each request at a falling edge and drops it at the next falling edge, then samples the response and the ring outputs at that falling edge, which lies half a cycle after the capture edge. It also samples `rsp_valid_o` again one idle cycle later to confirm that the pulse lasts a single cycle. A bench-side model built from the mask, window and length rules supplies every expected value in the offset and length-code sweeps.

// File: rtl/iommu_reg_pkg.sv
package iommu_reg_pkg;
  typedef enum logic [1:0] {
    RSP_OK       = 2'b00,
    RSP_UNMAPPED = 2'b01,
    RSP_ERROR    = 2'b10
  } rsp_status_e;

  localparam logic [1:0]  SZ_4B     = 2'd2;
  localparam logic [1:0]  SZ_8B     = 2'd3;
  localparam logic [63:0] DEV_MASK  = 64'h000F_FFFF_FFFF_F3FF;
  localparam logic [63:0] RING_MASK = 64'h0F0F_FFFF_FFFF_F000;
  localparam int unsigned RING_LEN_LSB = 56;

  // merge a 32- or 64-bit write into a 64-bit slot
  function automatic logic [63:0] merge_wr(logic [63:0] old_v, logic [63:0] wd,
                                           logic wide, logic upper);
    if (wide)       return wd;
    else if (upper) return {wd[31:0], old_v[31:0]};
    else            return {old_v[63:32], wd[31:0]};
  endfunction
endpackage

// File: rtl/iommu_acc_check.sv
module iommu_acc_check
  import iommu_reg_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int WIN0_LO = 'h0,
  parameter int WIN0_HI = 'h258,
  parameter int WIN1_LO = 'h1FF8,
  parameter int WIN1_HI = 'h2090
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              legal_o,
  output logic              known_o,
  output logic              wide_o
);
  int a;
  always_comb begin
    a       = int'(addr_i);
    wide_o  = (size_i == SZ_8B);
    if (size_i == SZ_8B)      legal_o = (addr_i[2:0] == 3'b000);
    else if (size_i == SZ_4B) legal_o = (addr_i[1:0] == 2'b00);
    else                      legal_o = 1'b0;
    known_o = ((a >= WIN0_LO) && (a <= WIN0_HI)) ||
              ((a >= WIN1_LO) && (a <= WIN1_HI));
  end
endmodule

// File: rtl/iommu_ring_len_dec.sv
module iommu_ring_len_dec #(
  parameter int LEN_W          = 4,
  parameter int MIN_CODE       = 8,
  parameter int ENT_BYTES_LOG2 = 4,
  localparam int ENT_W         = 2**LEN_W,
  localparam int BYTES_W       = ENT_W + ENT_BYTES_LOG2
) (
  input  logic [LEN_W-1:0]   code_i,
  output logic [ENT_W-1:0]   entries_o,
  output logic [BYTES_W-1:0] bytes_o,
  output logic               len_bad_o
);
  always_comb begin
    len_bad_o = (code_i < LEN_W'(MIN_CODE));
    entries_o = len_bad_o ? '0 : (ENT_W'(1) << code_i);
    bytes_o   = {entries_o, ENT_BYTES_LOG2'(0)};
  end

  always_comb begin
    if (!$isunknown(code_i)) begin
      assert_entries_pow2_R7: assert ($onehot0(entries_o))
        else $error("ring entry count not a power of two");
    end
  end
endmodule

// File: rtl/iommu_regfile.sv
module iommu_regfile
  import iommu_reg_pkg::*;
#(
  parameter int ADDR_W         = 14,
  parameter int LEN_W          = 4,
  parameter int MIN_CODE       = 8,
  parameter int ENT_BYTES_LOG2 = 4,
  parameter int WIN0_LO        = 'h0,
  parameter int WIN0_HI        = 'h258,
  parameter int WIN1_LO        = 'h1FF8,
  parameter int WIN1_HI        = 'h2090,
  parameter int DEV_OFF        = 'h000,
  parameter int CMD_OFF        = 'h008,
  parameter int EVT_OFF        = 'h010,
  parameter int PACK_OFF       = 'h158,
  localparam int ENT_W         = 2**LEN_W,
  localparam int BYTES_W       = ENT_W + ENT_BYTES_LOG2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic [63:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic [63:0]        rsp_rdata_o,
  output logic [1:0]         rsp_status_o,
  output logic [ENT_W-1:0]   cmd_entries_o,
  output logic [BYTES_W-1:0] cmd_bytes_o,
  output logic               cmd_len_bad_o,
  output logic [ENT_W-1:0]   evt_entries_o,
  output logic [BYTES_W-1:0] evt_bytes_o,
  output logic               evt_len_bad_o
);
  localparam int SLOT_W    = ADDR_W - 3;
  localparam int NUM_RINGS = 2;
  localparam logic [SLOT_W-1:0] DEV_SLOT  = SLOT_W'(DEV_OFF >> 3);
  localparam logic [SLOT_W-1:0] CMD_SLOT  = SLOT_W'(CMD_OFF >> 3);
  localparam logic [SLOT_W-1:0] EVT_SLOT  = SLOT_W'(EVT_OFF >> 3);
  localparam logic [SLOT_W-1:0] PACK_SLOT = SLOT_W'(PACK_OFF >> 3);

  function automatic logic [SLOT_W-1:0] ring_slot(int i);
    return (i == 0) ? CMD_SLOT : EVT_SLOT;
  endfunction

  logic              legal, known, wide, upper, wr_ok;
  logic [SLOT_W-1:0] slot;
  logic [63:0]       dev_bar;
  logic [NUM_RINGS-1:0][63:0] ring_bar;
  logic [31:0]       pack_lo, pack_hi;
  logic [NUM_RINGS-1:0][ENT_W-1:0]   ring_ent;
  logic [NUM_RINGS-1:0][BYTES_W-1:0] ring_bytes;
  logic [NUM_RINGS-1:0]              ring_bad;
  logic [63:0]       slot_val, rd_data;

  iommu_acc_check #(
    .ADDR_W(ADDR_W), .WIN0_LO(WIN0_LO), .WIN0_HI(WIN0_HI),
    .WIN1_LO(WIN1_LO), .WIN1_HI(WIN1_HI)
  ) u_acc (
    .addr_i (req_addr_i),
    .size_i (req_size_i),
    .legal_o(legal),
    .known_o(known),
    .wide_o (wide)
  );

  assign slot  = req_addr_i[ADDR_W-1:3];
  assign upper = req_addr_i[2];
  assign wr_ok = req_valid_i & req_write_i & legal & known;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_bar <= '0;
      pack_lo <= '0;
      pack_hi <= '0;
    end else if (wr_ok) begin
      if (slot == DEV_SLOT)
        dev_bar <= merge_wr(dev_bar, req_wdata_i, wide, upper) & DEV_MASK;
      if (slot == PACK_SLOT) begin
        if (wide) begin
          pack_lo <= req_wdata_i[31:0];
          pack_hi <= req_wdata_i[63:32];
        end else if (upper) pack_hi <= req_wdata_i[31:0];
        else                pack_lo <= req_wdata_i[31:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    logic [63:0] bar_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bar_q <= '0;
      else if (wr_ok && slot == ring_slot(g))
        bar_q <= merge_wr(bar_q, req_wdata_i, wide, upper) & RING_MASK;
    end
    assign ring_bar[g] = bar_q;

    iommu_ring_len_dec #(
      .LEN_W(LEN_W), .MIN_CODE(MIN_CODE), .ENT_BYTES_LOG2(ENT_BYTES_LOG2)
    ) u_len (
      .code_i   (bar_q[RING_LEN_LSB +: LEN_W]),
      .entries_o(ring_ent[g]),
      .bytes_o  (ring_bytes[g]),
      .len_bad_o(ring_bad[g])
    );
  end

  assign cmd_entries_o = ring_ent[0];
  assign cmd_bytes_o   = ring_bytes[0];
  assign cmd_len_bad_o = ring_bad[0];
  assign evt_entries_o = ring_ent[1];
  assign evt_bytes_o   = ring_bytes[1];
  assign evt_len_bad_o = ring_bad[1];

  always_comb begin
    slot_val = '0;
    if (slot == DEV_SLOT)  slot_val = dev_bar;
    if (slot == PACK_SLOT) slot_val = {pack_hi, pack_lo};
    for (int i = 0; i < NUM_RINGS; i++)
      if (slot == ring_slot(i)) slot_val = ring_bar[i];
    rd_data = wide ? slot_val
                   : {32'h0, (upper ? slot_val[63:32] : slot_val[31:0])};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_rdata_o  <= '0;
      rsp_status_o <= RSP_OK;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_rdata_o <= '0;
        if (!legal)                      rsp_status_o <= RSP_ERROR;
        else if (!known && !req_write_i) rsp_status_o <= RSP_UNMAPPED;
        else begin
          rsp_status_o <= RSP_OK;
          if (!req_write_i && known) rsp_rdata_o <= rd_data;
        end
      end
    end
  end

  logic [255:0] state_all;
  assign state_all = {dev_bar, ring_bar, pack_hi, pack_lo};

  assert_rsp_timing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(req_valid_i))
    else $error("response timing");

  assert_err_no_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !legal) |=> $stable(state_all))
    else $error("illegal access changed state");

  assert_err_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == RSP_ERROR) |-> rsp_rdata_o == '0)
    else $error("error response carries data");

  assert_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == RSP_UNMAPPED) |-> rsp_rdata_o == '0)
    else $error("unmapped read carries data");

  assert_unknown_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !known) |=> $stable(state_all))
    else $error("unknown write changed state");
endmodule

// File: tb/iommu_regfile_test.sv
module iommu_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic [1:0]  rsp_status;
  logic [15:0] cmd_ent, evt_ent;
  logic [19:0] cmd_bytes, evt_bytes;
  logic        cmd_bad, evt_bad;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [63:0] m_dev = '0, m_cmd = '0, m_evt = '0;
  logic [31:0] m_lo = '0, m_hi = '0;
  logic [63:0] r_data;
  logic [1:0]  r_stat;
  logic        r_valid;

  localparam logic [63:0] DMASK = 64'h000F_FFFF_FFFF_F3FF;
  localparam logic [63:0] RMASK = 64'h0F0F_FFFF_FFFF_F000;

  always #2.5 clk = ~clk;

  iommu_regfile uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_status_o(rsp_status),
    .cmd_entries_o(cmd_ent), .cmd_bytes_o(cmd_bytes), .cmd_len_bad_o(cmd_bad),
    .evt_entries_o(evt_ent), .evt_bytes_o(evt_bytes), .evt_len_bad_o(evt_bad)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_known(int a);
    return (a <= 'h258) || (a >= 'h1FF8 && a <= 'h2090);
  endfunction

  function automatic bit is_legal(int a, logic [1:0] sz);
    return (sz == 2'd3 && a % 8 == 0) || (sz == 2'd2 && a % 4 == 0);
  endfunction

  function automatic logic [63:0] m_slot(int a);
    case (a / 8)
      0:        return m_dev;
      1:        return m_cmd;
      2:        return m_evt;
      'h158/8:  return {m_hi, m_lo};
      default:  return 64'h0;
    endcase
  endfunction

  function automatic logic [63:0] exp_rd(int a, logic [1:0] sz);
    logic [63:0] s;
    if (!is_legal(a, sz) || !is_known(a)) return 64'h0;
    s = m_slot(a);
    if (sz == 2'd3) return s;
    return (a % 8 == 4) ? {32'h0, s[63:32]} : {32'h0, s[31:0]};
  endfunction

  function automatic logic [1:0] exp_st(int a, logic [1:0] sz, bit wr);
    if (!is_legal(a, sz)) return 2'd2;
    if (!is_known(a) && !wr) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [63:0] mrg(logic [63:0] o, logic [63:0] w, int a, logic [1:0] sz);
    if (sz == 2'd3) return w;
    return (a % 8 == 4) ? {w[31:0], o[31:0]} : {o[63:32], w[31:0]};
  endfunction

  task automatic model_wr(int a, logic [1:0] sz, logic [63:0] w);
    if (!is_legal(a, sz) || !is_known(a)) return;
    case (a / 8)
      0: m_dev = mrg(m_dev, w, a, sz) & DMASK;
      1: m_cmd = mrg(m_cmd, w, a, sz) & RMASK;
      2: m_evt = mrg(m_evt, w, a, sz) & RMASK;
      'h158/8: begin
        if (sz == 2'd3) begin m_lo = w[31:0]; m_hi = w[63:32]; end
        else if (a % 8 == 4) m_hi = w[31:0];
        else m_lo = w[31:0];
      end
      default: ;
    endcase
  endtask

  task automatic acc(bit wr, int a, logic [1:0] sz, logic [63:0] w);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 14'(a); req_size = sz; req_wdata = w;
    @(negedge clk);
    req_valid = 1'b0;
    r_valid = rsp_valid; r_data = rsp_rdata; r_stat = rsp_status;
    if (wr) model_wr(a, sz, w);
  endtask

  task automatic rd_chk(string tag, int a, logic [1:0] sz);
    acc(0, a, sz, 64'h0);
    chk(tag, r_data, exp_rd(a, sz));
    chk(tag, 64'(r_stat), 64'(exp_st(a, sz, 0)));
  endtask

  task automatic chk_all(string tag);
    rd_chk(tag, 'h000, 2'd3);
    rd_chk(tag, 'h008, 2'd3);
    rd_chk(tag, 'h010, 2'd3);
    rd_chk(tag, 'h158, 2'd3);
  endtask

  task automatic chk_ring(string tag, bit evt, int code);
    logic [63:0] e;
    e = (code >= 8) ? (64'h1 << code) : 64'h0;
    chk(tag, 64'(evt ? evt_ent : cmd_ent), e);
    chk(tag, 64'(evt ? evt_bytes : cmd_bytes), e * 16);
    chk(tag, 64'(evt ? evt_bad : cmd_bad), 64'(code < 8));
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'h0);
    chk_ring("R1 cmd", 0, 0);
    chk_ring("R1 evt", 1, 0);
    chk_all("R1 regs");

    // R2 single-cycle response
    acc(0, 'h0, 2'd3, 64'h0);
    chk("R2 valid", 64'(r_valid), 64'h1);
    @(negedge clk);
    chk("R2 idle", 64'(rsp_valid), 64'h0);
    acc(1, 'h3000, 2'd2, 64'h5);
    chk("R2 valid wr", 64'(r_valid), 64'h1);

    // R4 R5 masks
    acc(1, 'h000, 2'd3, '1); chk("R4 st", 64'(r_stat), 64'h0);
    acc(1, 'h008, 2'd3, '1);
    acc(1, 'h010, 2'd3, '1);
    acc(0, 'h000, 2'd3, 0); chk("R4 dev mask", r_data, DMASK);
    acc(0, 'h008, 2'd3, 0); chk("R5 cmd mask", r_data, RMASK);
    acc(0, 'h010, 2'd3, 0); chk("R5 evt mask", r_data, RMASK);

    // R6 half accesses
    acc(1, 'h000, 2'd3, 64'h0);
    acc(1, 'h004, 2'd2, 64'hAAAA_BBBB_FFFF_FFFF);
    acc(0, 'h000, 2'd3, 0); chk("R6 dev upper", r_data, 64'h000F_FFFF_0000_0000);
    acc(1, 'h000, 2'd2, 64'h1234_5678_DEAD_BEEF);
    acc(0, 'h000, 2'd3, 0); chk("R6 dev lower", r_data, 64'h000F_FFFF_DEAD_B2EF);
    acc(0, 'h004, 2'd2, 0); chk("R6 rd upper", r_data, 64'h0000_0000_000F_FFFF);
    acc(0, 'h000, 2'd2, 0); chk("R6 rd lower", r_data, 64'h0000_0000_DEAD_B2EF);
    acc(1, 'h00C, 2'd2, 64'hFFFF_FFFF);
    acc(0, 'h008, 2'd3, 0); chk("R6 cmd upper", r_data, m_cmd);

    // R7 length decode, both rings
    for (int c = 0; c < 16; c++) begin
      acc(1, 'h008, 2'd3, (64'(c) << 56) | 64'h0000_0012_3456_7000);
      chk_ring("R7 cmd", 0, c);
      acc(1, 'h014, 2'd2, 64'(c) << 24);
      chk_ring("R7 evt", 1, c);
    end
    acc(1, 'h008, 2'd3, 64'hF000_0000_0000_0000);
    chk_ring("R7 masked code", 0, 0);

    // R10 packed pair
    acc(1, 'h158, 2'd2, 64'hFFFF_FFFF_1111_2222);
    acc(1, 'h15C, 2'd2, 64'h3333_4444);
    acc(0, 'h158, 2'd3, 0); chk("R10 pair rd", r_data, 64'h3333_4444_1111_2222);
    acc(1, 'h158, 2'd3, 64'h8765_4321_0FED_CBA9);
    acc(0, 'h15C, 2'd2, 0); chk("R10 hi rd", r_data, 64'h0000_0000_8765_4321);
    acc(0, 'h158, 2'd2, 0); chk("R10 lo rd", r_data, 64'h0000_0000_0FED_CBA9);

    // R8 window sweep, 4- and 8-byte reads
    for (int a = 0; a <= 'h2200; a += 4) rd_chk("R8 rd4", a, 2'd2);
    for (int a = 0; a <= 'h2200; a += 8) rd_chk("R8 rd8", a, 2'd3);
    rd_chk("R8 top", 'h3FF8, 2'd3);

    // R9 writes with no storage
    for (int a = 0; a <= 'h2200; a += 8) begin
      if (a != 'h000 && a != 'h008 && a != 'h010 && a != 'h158) begin
        acc(1, a, 2'd3, '1);
        chk("R9 wr st", 64'(r_stat), 64'h0);
      end
    end
    chk_all("R9 unchanged");

    // R3 illegal size / misalignment
    for (int s = 0; s < 2; s++) begin
      acc(1, 'h000, 2'(s), '1);
      chk("R3 size st", 64'(r_stat), 64'h2);
      acc(0, 'h008, 2'(s), 0);
      chk("R3 size rd", r_data, 64'h0);
      chk("R3 size rd st", 64'(r_stat), 64'h2);
    end
    acc(1, 'h004, 2'd3, '1); chk("R3 mis8", 64'(r_stat), 64'h2);
    acc(1, 'h00A, 2'd2, '1); chk("R3 mis4", 64'(r_stat), 64'h2);
    acc(1, 'h15C, 2'd3, '1); chk("R3 mis pack", 64'(r_stat), 64'h2);
    acc(0, 'h15C, 2'd3, 0);  chk("R3 mis rd", r_data, 64'h0);
    acc(0, 'h3001, 2'd2, 0); chk("R3 mis unk", 64'(r_stat), 64'h2);
    chk_all("R3 unchanged");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule